// File: doc/BRIEF.md
# Port Status Indicator Controller

This block drives a green/amber LED pair for every downstream port of a hub. Each port can run in automatic mode, where its colour follows the port's live status (fault shown in amber, a working link in green, anything else dark), or in manual mode, where the host picks a colour or a blinking pattern through a small selector write interface. Every port comes out of reset in automatic mode.

A single shared blink timer sets the rhythm for all blinking patterns, so ports that blink do so in step. While the hub is suspended every LED is held dark whatever the mode. The stored modes are kept, so the previous colours come back when suspend is released. The LED outputs are registered, which keeps them glitch-free towards the pads.

Top module: `port_indicator_ctrl`

## Requirements
- R1: While `rst_n` is low, all LED outputs are low, every port is placed in automatic mode and the blink timer restarts in its lit phase.
- R2: In automatic mode a port with `port_fault` high shows amber, even when it is enabled. With no fault, a port that is powered, connected and enabled shows green. Any other status shows off. The outputs follow a status change one clock edge after the edge that samples it.
- R3: While `hub_suspended` is high, every green and amber output is low one edge after it is sampled. When it goes low, the colours implied by the stored modes return on the following edge.
- R4: No port ever drives green and amber in the same cycle.
- R5: A write (`sel_we` high, port index on `sel_port`) stores selector code 1 (amber), 2 (green) or 3 (off) for the addressed port. The new colour shows on the second edge after the write is sampled.
- R6: Code 4 (blink amber) and code 5 (blink green) light their colour during the lit phase and go dark in the other phase. The phase starts lit after reset and flips every `BLINK_HALF` clock edges. All ports share the same phase.
- R7: Code 6 (alternate) shows green in the lit phase and amber in the other phase.
- R8: A write with code 7 is ignored, and the addressed port keeps its previous mode.
- R9: A write with code 0 returns the addressed port to automatic mode.
- R10: In a manual mode, the port's status inputs have no effect on its LEDs.
- R11: A write changes only the addressed port's mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hub_suspended | input | 1 | Hub suspended; forces all LEDs dark |
| sel_we | input | 1 | Selector write strobe |
| sel_port | input | IDX_W | Port addressed by the write |
| sel_code | input | 3 | Selector code (0 auto, 1 amber, 2 green, 3 off, 4 blink amber, 5 blink green, 6 alternate, 7 ignored) |
| port_powered | input | NUM_PORTS | Per-port power is on |
| port_connected | input | NUM_PORTS | Per-port device is attached |
| port_enabled | input | NUM_PORTS | Per-port link is enabled |
| port_fault | input | NUM_PORTS | Per-port error or overcurrent |
| led_green | output | NUM_PORTS | Green LED drive per port |
| led_amber | output | NUM_PORTS | Amber LED drive per port |

## Verification
Status and suspend changes reach the LEDs on the first edge after they are sampled. A selector write reaches the LEDs on the second edge, because it first passes through the mode register. The blink phase used at the n-th edge after reset release is floor((n-1)/BLINK_HALF) mod 2. The bench reference model works out each edge's expected outputs from the inputs seen at that edge and the modes stored before it. It then compares them at the following falling edge, when the registered outputs are stable. Directed checks on ignored codes, per-port isolation and the return to automatic mode wait the same two edges after the write before they sample.

// File: rtl/pi_pkg.sv
// Shared types for the port status indicator controller.
// Assumes a 3-bit selector code; code values are part of the write interface.
package pi_pkg;

    typedef enum logic [2:0] {
        IND_AUTO        = 3'd0,
        IND_AMBER       = 3'd1,
        IND_GREEN       = 3'd2,
        IND_OFF         = 3'd3,
        IND_BLINK_AMBER = 3'd4,
        IND_BLINK_GREEN = 3'd5,
        IND_ALTERNATE   = 3'd6,
        IND_RESERVED    = 3'd7
    } ind_sel_e;

    typedef struct packed {
        logic green;
        logic amber;
    } led_pair_t;

endpackage

// File: rtl/pi_blink_timer.sv
// Shared blink phase generator: phase_o is 0 (lit) for HALF edges, then 1
// for HALF edges, and so on. Assumes HALF >= 2.
module pi_blink_timer #(
    parameter int HALF = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    // Count edges within a half period and flip the phase at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_o <= 1'b0;
        end else if (cnt_q == CW'(HALF - 1)) begin
            cnt_q   <= '0;
            phase_o <= ~phase_o;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pi_mode_regs.sv
// Per-port selector storage. A write updates only the addressed port.
// The reserved code is dropped. Reset returns every port to automatic mode.
// Assumes an index beyond NUM_PORTS-1 simply matches no port.
module pi_mode_regs
    import pi_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          port,
    input  logic [2:0]                code,
    output ind_sel_e [NUM_PORTS-1:0]  mode_o
);
    // Hold each port's selected mode and apply accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) mode_o[p] <= IND_AUTO;
        end else if (we && (code != IND_RESERVED)) begin
            for (int p = 0; p < NUM_PORTS; p++)
                if (port == IDX_W'(p)) mode_o[p] <= ind_sel_e'(code);
        end
    end
endmodule

// File: rtl/pi_port_drive.sv
// Combinational colour decode for one port, from its mode, its status,
// the shared blink phase and the suspend flag. It never asserts both colours.
module pi_port_drive
    import pi_pkg::*;
(
    input  ind_sel_e  mode,
    input  logic      phase,
    input  logic      suspended,
    input  logic      powered,
    input  logic      connected,
    input  logic      enabled,
    input  logic      fault,
    output led_pair_t led
);
    // Select the colour pair; suspend overrides every mode.
    always_comb begin
        led = '0;
        if (!suspended) begin
            case (mode)
                IND_AUTO: begin
                    if (fault)                               led.amber = 1'b1;
                    else if (powered && connected && enabled) led.green = 1'b1;
                end
                IND_AMBER:       led.amber = 1'b1;
                IND_GREEN:       led.green = 1'b1;
                IND_BLINK_AMBER: led.amber = ~phase;
                IND_BLINK_GREEN: led.green = ~phase;
                IND_ALTERNATE: begin
                    led.green = ~phase;
                    led.amber = phase;
                end
                default:         led = '0;
            endcase
        end
    end
endmodule

// File: rtl/port_indicator_ctrl.sv
// Top level of the port status indicator controller. It stores per-port
// modes, shares one blink timer and registers the LED outputs.
// Assumes synchronous inputs in the clk domain.
module port_indicator_ctrl
    import pi_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int BLINK_HALF = 62_500_000,
    localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hub_suspended,
    input  logic                 sel_we,
    input  logic [IDX_W-1:0]     sel_port,
    input  logic [2:0]           sel_code,
    input  logic [NUM_PORTS-1:0] port_powered,
    input  logic [NUM_PORTS-1:0] port_connected,
    input  logic [NUM_PORTS-1:0] port_enabled,
    input  logic [NUM_PORTS-1:0] port_fault,
    output logic [NUM_PORTS-1:0] led_green,
    output logic [NUM_PORTS-1:0] led_amber
);
    ind_sel_e [NUM_PORTS-1:0] mode_q;
    logic                     phase;
    led_pair_t                pair_d [NUM_PORTS];

    pi_blink_timer #(.HALF(BLINK_HALF)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    pi_mode_regs #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_modes (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sel_we),
        .port   (sel_port),
        .code   (sel_code),
        .mode_o (mode_q)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pi_port_drive u_drive (
            .mode      (mode_q[p]),
            .phase     (phase),
            .suspended (hub_suspended),
            .powered   (port_powered[p]),
            .connected (port_connected[p]),
            .enabled   (port_enabled[p]),
            .fault     (port_fault[p]),
            .led       (pair_d[p])
        );

        // Register this port's LED pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                led_green[p] <= 1'b0;
                led_amber[p] <= 1'b0;
            end else begin
                led_green[p] <= pair_d[p].green;
                led_amber[p] <= pair_d[p].amber;
            end
        end
    end
endmodule

// File: rtl/pi_checker.sv
// Assertion checker for port_indicator_ctrl, attached with bind.
module pi_checker
    import pi_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     hub_suspended,
    input logic                     sel_we,
    input logic [IDX_W-1:0]         sel_port,
    input logic [2:0]               sel_code,
    input logic [NUM_PORTS-1:0]     port_fault,
    input ind_sel_e [NUM_PORTS-1:0] mode,
    input logic [NUM_PORTS-1:0]     led_green,
    input logic [NUM_PORTS-1:0]     led_amber
);
    AST_RESET_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (led_green == '0 && led_amber == '0)); // R1

    AST_RESERVED_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && sel_code == 3'd7) |=> $stable(mode)); // R8

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        AST_NO_DUAL_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
            !(led_green[p] && led_amber[p])); // R4

        AST_SUSPEND_DARK: assert property (@(posedge clk) disable iff (!rst_n)
            hub_suspended |=> (!led_green[p] && !led_amber[p])); // R3

        AST_AUTO_FAULT_AMBER: assert property (@(posedge clk) disable iff (!rst_n)
            (!hub_suspended && mode[p] == IND_AUTO && port_fault[p]) |=> led_amber[p]); // R2

        AST_MANUAL_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
            (!hub_suspended && mode[p] == IND_GREEN) |=> led_green[p]); // R10

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_we && sel_code != 3'd7 && sel_port == IDX_W'(p))
                |=> (mode[p] == $past(sel_code))); // R5
    end
endmodule

bind port_indicator_ctrl pi_checker #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_pi_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .hub_suspended (hub_suspended),
    .sel_we        (sel_we),
    .sel_port      (sel_port),
    .sel_code      (sel_code),
    .port_fault    (port_fault),
    .mode          (mode_q),
    .led_green     (led_green),
    .led_amber     (led_amber)
);

// File: tb/port_indicator_ctrl_bench.sv
module port_indicator_ctrl_bench;
    localparam int NP   = 4;
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hub_suspended = 1'b0;
    logic          sel_we = 1'b0;
    logic [1:0]    sel_port = '0;
    logic [2:0]    sel_code = '0;
    logic [NP-1:0] pw = '0, cn = '0, en = '0, ft = '0;
    logic [NP-1:0] led_green, led_amber;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    int    m_mode [NP];
    int    n_edges = 0;
    bit    exp_g [NP];
    bit    exp_a [NP];
    string exp_tag [NP];

    always #4 clk = ~clk;

    port_indicator_ctrl #(.NUM_PORTS(NP), .BLINK_HALF(HALF)) u_port_indicator_ctrl (
        .clk(clk), .rst_n(rst_n), .hub_suspended(hub_suspended),
        .sel_we(sel_we), .sel_port(sel_port), .sel_code(sel_code),
        .port_powered(pw), .port_connected(cn), .port_enabled(en), .port_fault(ft),
        .led_green(led_green), .led_amber(led_amber));

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: expected LED state after each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_mode[p] = 0; exp_g[p] = 0; exp_a[p] = 0; exp_tag[p] = "R1";
            end
            n_edges = 0;
        end else begin
            bit lit;
            lit = ((n_edges / HALF) % 2) == 0;
            for (int p = 0; p < NP; p++) begin
                exp_g[p] = 0; exp_a[p] = 0;
                if (hub_suspended) exp_tag[p] = "R3";
                else begin
                    case (m_mode[p])
                        0: begin
                            exp_tag[p] = "R2";
                            if (ft[p]) exp_a[p] = 1;
                            else if (pw[p] && cn[p] && en[p]) exp_g[p] = 1;
                        end
                        1: begin exp_a[p] = 1; exp_tag[p] = "R5,R10"; end
                        2: begin exp_g[p] = 1; exp_tag[p] = "R5,R10"; end
                        3: exp_tag[p] = "R5,R10";
                        4: begin exp_a[p] = lit; exp_tag[p] = "R6"; end
                        5: begin exp_g[p] = lit; exp_tag[p] = "R6"; end
                        default: begin exp_g[p] = lit; exp_a[p] = !lit; exp_tag[p] = "R7"; end
                    endcase
                end
            end
            if (sel_we && sel_code != 3'd7) m_mode[sel_port] = int'(sel_code);
            n_edges++;
        end
    end

    // Compare on every falling edge, when the registered outputs are stable.
    always @(negedge clk) begin
        if (!done) begin
            for (int p = 0; p < NP; p++) begin
                check(led_green[p] == exp_g[p], exp_tag[p], $sformatf("port %0d green", p),
                      led_green[p], exp_g[p]);
                check(led_amber[p] == exp_a[p], exp_tag[p], $sformatf("port %0d amber", p),
                      led_amber[p], exp_a[p]);
                check(!(led_green[p] && led_amber[p]), "R4", $sformatf("port %0d both on", p),
                      1, 0);
            end
        end
    end

    task automatic wr(input int port, input int code);
        @(negedge clk);
        sel_we = 1'b1; sel_port = 2'(port); sel_code = 3'(code);
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        check(led_green == '0 && led_amber == '0, "R1", "outputs in reset",
              int'({led_green, led_amber}), 0);
        rst_n = 1'b1;
        // Automatic mode under assorted status patterns
        pw = 4'b1111; cn = 4'b1101; en = 4'b1001; ft = 4'b1010;
        idle(4);
        pw = 4'b0111; cn = 4'b0111; en = 4'b0111; ft = 4'b0000;
        idle(3);
        ft = 4'b0100;
        idle(3);
        // Suspend and release
        hub_suspended = 1'b1; idle(3);
        hub_suspended = 1'b0; idle(3);
        // Manual steady colours while status moves
        wr(0, 2); wr(1, 1); wr(2, 3); wr(3, 5);
        ft = 4'b1111; idle(4);
        en = 4'b0000; ft = 4'b0000; idle(4);
        // Blink patterns over several phases, with a suspend in the middle
        wr(0, 4); wr(1, 6);
        idle(14);
        hub_suspended = 1'b1; idle(4);
        hub_suspended = 1'b0; idle(14);
        // Ignored code keeps mode (R8)
        wr(2, 2); idle(1);
        wr(2, 7); idle(1);
        check(led_green[2] == 1'b1 && led_amber[2] == 1'b0, "R8", "port 2 after code 7",
              int'(led_green[2]), 1);
        // Isolation: a write to port 3 leaves port 2 alone (R11)
        wr(3, 1); idle(1);
        check(led_green[2] == 1'b1, "R11", "port 2 after port 3 write", int'(led_green[2]), 1);
        check(led_amber[3] == 1'b1, "R11", "port 3 amber", int'(led_amber[3]), 1);
        // Back to automatic (R9)
        ft = 4'b0100; wr(2, 0); idle(1);
        check(led_amber[2] == 1'b1 && led_green[2] == 1'b0, "R9", "port 2 auto fault",
              int'(led_amber[2]), 1);
        // Reset in mid-run returns to automatic mode and restarts the phase (R1)
        rst_n = 1'b0; idle(2);
        rst_n = 1'b1; ft = 4'b0000; pw = 4'b1111; cn = 4'b1111; en = 4'b1111;
        idle(2);
        check(led_green == 4'b1111, "R1", "auto after reset", int'(led_green), 15);
        wr(1, 5); idle(16);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule